// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the per-source state for a bank of interrupt inputs and turns input activity into offers for a single presentation unit. Each source is typed once as either level-sensitive or message (pulse) type, and carries a routing entry with a target server, a priority and a saved priority. A priority of 0xFF masks the source. An offer carries a global source number, which is the local index plus a fixed base of 0x1000, along with the priority and server of that source.

The presentation unit answers with reject, end-of-interrupt and resend strobes. Each strobe names a global number, or in the case of resend reaches every source. Message sources keep a rejected flag and a masked-pending flag so that lost deliveries can be made again later. Level sources keep an asserted flag and a sent flag, so that they present again only while their input is still high.

Queued offers leave one per cycle on a valid/ready handshake, lowest index first. A soft clear returns every routing entry and flag to its idle value but keeps the types. A combinational read port exposes any entry.

Top module: `irqsrc_ctrl`

## Requirements
- R1: After reset every entry reads priority 0xFF, saved priority 0xFF, server 0, flags 0 and untyped, and no offer is valid.
- R2: An offer names source i as global number 0x1000+i. A reject or EOI number outside 0x1000 to 0x1000+N-1 changes no state.
- R3: A message source whose input is high in a cycle is queued for offer with its priority and server when unmasked. When it is masked, its masked-pending flag (read flags bit 3) is set instead and no offer appears.
- R4: A level source copies its input into its asserted flag (flags bit 0) every cycle. On an input change, routing write or resend, it is queued and its sent flag (flags bit 1) is set if it is unmasked, asserted and not sent. While its input stays high it makes no further offer.
- R5: A reject sets the rejected flag (flags bit 2) of a message source and clears the sent flag of a level source.
- R6: A resend clears the rejected flag of every message source that has it and queues that source if it is unmasked. Each level source applies the R4 offer rule.
- R7: EOI clears the sent flag of a level source and has no effect on a message source.
- R8: A routing write stores server, priority and saved priority. A message source that is masked-pending and becomes unmasked has the flag cleared and is queued. A level source applies the R4 rule.
- R9: A routing write that masks a queued source withdraws the offer. A message source then becomes masked-pending, and a level source has its sent flag cleared.
- R10: Soft clear returns flags, servers and priorities to their R1 values and drops queued offers, but keeps each source's type.
- R11: A type assignment takes effect only on an untyped source. Assigning a typed source raises the error output one cycle later and leaves the type unchanged.
- R12: At most one offer is valid per cycle, belonging to the lowest queued index. It stays until ready is high, and an accepted source leaves the queue.
- R13: When a reject for a source arrives in the same cycle as an event that would offer it, the reject is applied first, so a sent level source is offered again at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears everything including types |
| soft_clr | input | 1 | Clears entries and flags, keeps types |
| src_in | input | N | Source inputs: level, or one-cycle arrival pulses |
| ty_we | input | 1 | Type assignment strobe |
| ty_idx | input | IDX_W | Source index to type |
| ty_level | input | 1 | 1 = level type, 0 = message type |
| ty_err | output | 1 | Pulse: assignment to an already typed source |
| rt_we | input | 1 | Routing entry write strobe |
| rt_idx | input | IDX_W | Source index to write |
| rt_server | input | SRV_W | Target server |
| rt_prio | input | 8 | Priority, 0xFF masks |
| rt_saved | input | 8 | Saved priority |
| ofr_valid | output | 1 | Offer valid |
| ofr_ready | input | 1 | Offer accepted by presentation unit |
| ofr_num | output | NUM_W | Global source number of offer |
| ofr_prio | output | 8 | Priority of offer |
| ofr_server | output | SRV_W | Server of offer |
| rej_valid | input | 1 | Reject strobe |
| rej_num | input | NUM_W | Global number rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number completed |
| resend | input | 1 | Resend strobe for all sources |
| rd_idx | input | IDX_W | Read port index |
| rd_typed | output | 1 | Entry has been typed |
| rd_level | output | 1 | Entry is level type |
| rd_flags | output | 4 | {pending, rejected, sent, asserted} |
| rd_prio | output | 8 | Entry priority |
| rd_saved | output | 8 | Entry saved priority |
| rd_server | output | SRV_W | Entry server |

## Verification
The functions that can meet in one cycle are an incoming reject (or EOI) and an event that offers the same source: a resend, an input change or a routing write. Collisions are forced by directed steps, such as a reject of a sent level source together with a resend. They also arise freely in a long random phase, where rejects, EOIs, resends, masking writes and stalled offers are mixed. In every cycle a bench model built from the requirements predicts the offer and the read port, and it applies the reject before the offer rule.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;
    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_OFF = 8'hFF;
    typedef logic [PRIO_W-1:0] prio_t;
    // read-port flag bit positions
    localparam int FL_ASSERTED = 0;
    localparam int FL_SENT     = 1;
    localparam int FL_REJECTED = 2;
    localparam int FL_PENDING  = 3;
endpackage

// File: rtl/irqsrc_decode.sv
module irqsrc_decode #(
    parameter int N     = 16,
    parameter int NUM_W = 16,
    parameter int BASE  = 32'h1000
) (
    input  logic             vld,
    input  logic [NUM_W-1:0] num,
    output logic [N-1:0]     hit
);
    localparam logic [NUM_W-1:0] BASE_V = NUM_W'(BASE);

    logic             above;
    logic [NUM_W-1:0] off;

    assign above = (num >= BASE_V);
    assign off   = num - BASE_V;

    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = vld && above && (off == NUM_W'(i));
    end
endmodule

// File: rtl/irqsrc_pick.sv
module irqsrc_pick #(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqsrc_entry.sv
module irqsrc_entry
    import irqsrc_pkg::*;
#(
    parameter int SRV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             ty_we,
    input  logic             ty_level,
    input  logic             rt_we,
    input  logic [SRV_W-1:0] rt_server,
    input  prio_t            rt_prio,
    input  prio_t            rt_saved,
    input  logic             in_sig,
    input  logic             rej_hit,
    input  logic             eoi_hit,
    input  logic             resend,
    input  logic             grant,
    output logic             typed,
    output logic             level,
    output logic             queued,
    output logic [3:0]       flags,
    output prio_t            prio,
    output prio_t            saved,
    output logic [SRV_W-1:0] server
);
    typedef struct packed {
        logic             typed;
        logic             lvl;
        logic             asserted;
        logic             sent;
        logic             rejected;
        logic             pending;
        logic             queued;
        logic [SRV_W-1:0] server;
        prio_t            prio;
        prio_t            saved;
    } ent_t;

    ent_t st_d, st_q;
    logic masked_now;
    logic lvl_evt;

    always_comb begin
        st_d       = st_q;
        masked_now = 1'b0;
        lvl_evt    = 1'b0;
        if (soft_clr) begin
            st_d       = '0;
            st_d.typed = st_q.typed;
            st_d.lvl   = st_q.lvl;
            st_d.prio  = PRIO_OFF;
            st_d.saved = PRIO_OFF;
        end else begin
            if (ty_we && !st_q.typed) begin
                st_d.typed = 1'b1;
                st_d.lvl   = ty_level;
            end
            if (grant) st_d.queued = 1'b0;
            // reject and EOI act before any offer decision of this cycle
            if (rej_hit) begin
                if (st_q.lvl) st_d.sent = 1'b0;
                else          st_d.rejected = 1'b1;
            end
            if (eoi_hit && st_q.lvl) st_d.sent = 1'b0;
            if (rt_we) begin
                st_d.server = rt_server;
                st_d.prio   = rt_prio;
                st_d.saved  = rt_saved;
            end
            masked_now = (st_d.prio == PRIO_OFF);
            if (rt_we && masked_now && st_d.queued) begin
                st_d.queued = 1'b0;
                if (st_q.lvl) st_d.sent = 1'b0;
                else          st_d.pending = 1'b1;
            end
            if (st_q.lvl) begin
                lvl_evt       = (in_sig != st_q.asserted) || rt_we || resend;
                st_d.asserted = in_sig;
                st_d.pending  = 1'b0;
                st_d.rejected = 1'b0;
                if (lvl_evt && !masked_now && in_sig && !st_d.sent) begin
                    st_d.sent   = 1'b1;
                    st_d.queued = 1'b1;
                end
            end else begin
                if (resend && st_d.rejected) begin
                    st_d.rejected = 1'b0;
                    if (!masked_now) st_d.queued = 1'b1;
                end
                if (in_sig) begin
                    if (masked_now) st_d.pending = 1'b1;
                    else            st_d.queued  = 1'b1;
                end
                if (rt_we && st_d.pending && !masked_now) begin
                    st_d.pending = 1'b0;
                    st_d.queued  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.prio  <= PRIO_OFF;
            st_q.saved <= PRIO_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign typed  = st_q.typed;
    assign level  = st_q.lvl;
    assign queued = st_q.queued;
    assign prio   = st_q.prio;
    assign saved  = st_q.saved;
    assign server = st_q.server;
    always_comb begin
        flags              = '0;
        flags[FL_ASSERTED] = st_q.asserted;
        flags[FL_SENT]     = st_q.sent;
        flags[FL_REJECTED] = st_q.rejected;
        flags[FL_PENDING]  = st_q.pending;
    end
endmodule

// File: rtl/irqsrc_ctrl.sv
module irqsrc_ctrl
    import irqsrc_pkg::*;
#(
    parameter int N     = 16,
    parameter int NUM_W = 16,
    parameter int BASE  = 32'h1000,
    parameter int SRV_W = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic [N-1:0]     src_in,
    input  logic             ty_we,
    input  logic [IDX_W-1:0] ty_idx,
    input  logic             ty_level,
    output logic             ty_err,
    input  logic             rt_we,
    input  logic [IDX_W-1:0] rt_idx,
    input  logic [SRV_W-1:0] rt_server,
    input  logic [7:0]       rt_prio,
    input  logic [7:0]       rt_saved,
    output logic             ofr_valid,
    input  logic             ofr_ready,
    output logic [NUM_W-1:0] ofr_num,
    output logic [7:0]       ofr_prio,
    output logic [SRV_W-1:0] ofr_server,
    input  logic             rej_valid,
    input  logic [NUM_W-1:0] rej_num,
    input  logic             eoi_valid,
    input  logic [NUM_W-1:0] eoi_num,
    input  logic             resend,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_typed,
    output logic             rd_level,
    output logic [3:0]       rd_flags,
    output logic [7:0]       rd_prio,
    output logic [7:0]       rd_saved,
    output logic [SRV_W-1:0] rd_server
);
    localparam logic [NUM_W-1:0] BASE_V = NUM_W'(BASE);

    logic [N-1:0]       rej_hit, eoi_hit, grant;
    logic [N-1:0]       typed_v, level_v, queued_v, pend_v, sent_v;
    logic [3:0]         flags_a  [N];
    prio_t              prio_a   [N];
    prio_t              saved_a  [N];
    logic [SRV_W-1:0]   server_a [N];
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;
    logic               err_d, err_q;

    irqsrc_decode #(.N(N), .NUM_W(NUM_W), .BASE(BASE)) u_rej_dec (
        .vld(rej_valid), .num(rej_num), .hit(rej_hit));
    irqsrc_decode #(.N(N), .NUM_W(NUM_W), .BASE(BASE)) u_eoi_dec (
        .vld(eoi_valid), .num(eoi_num), .hit(eoi_hit));

    irqsrc_pick #(.N(N), .IW(IDX_W)) u_pick (
        .req(queued_v), .any(pick_any), .idx(pick_idx));

    for (genvar i = 0; i < N; i++) begin : g_src
        assign grant[i] = pick_any && ofr_ready && (pick_idx == IDX_W'(i));
        irqsrc_entry #(.SRV_W(SRV_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_clr),
            .ty_we    (ty_we && (ty_idx == IDX_W'(i))),
            .ty_level (ty_level),
            .rt_we    (rt_we && (rt_idx == IDX_W'(i))),
            .rt_server(rt_server),
            .rt_prio  (rt_prio),
            .rt_saved (rt_saved),
            .in_sig   (src_in[i]),
            .rej_hit  (rej_hit[i]),
            .eoi_hit  (eoi_hit[i]),
            .resend   (resend),
            .grant    (grant[i]),
            .typed    (typed_v[i]),
            .level    (level_v[i]),
            .queued   (queued_v[i]),
            .flags    (flags_a[i]),
            .prio     (prio_a[i]),
            .saved    (saved_a[i]),
            .server   (server_a[i])
        );
        assign pend_v[i] = flags_a[i][FL_PENDING];
        assign sent_v[i] = flags_a[i][FL_SENT];
    end

    assign ofr_valid  = pick_any;
    assign ofr_num    = BASE_V + NUM_W'(pick_idx);
    assign ofr_prio   = prio_a[pick_idx];
    assign ofr_server = server_a[pick_idx];

    assign rd_typed  = typed_v[rd_idx];
    assign rd_level  = level_v[rd_idx];
    assign rd_flags  = flags_a[rd_idx];
    assign rd_prio   = prio_a[rd_idx];
    assign rd_saved  = saved_a[rd_idx];
    assign rd_server = server_a[rd_idx];

    always_comb begin
        err_d = ty_we && typed_v[ty_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign ty_err = err_q;
endmodule

// File: rtl/irqsrc_ctrl_chk.sv
module irqsrc_ctrl_chk #(
    parameter int N     = 16,
    parameter int NUM_W = 16,
    parameter int BASE  = 32'h1000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ofr_valid,
    input logic [NUM_W-1:0] ofr_num,
    input logic [7:0]       ofr_prio,
    input logic [N-1:0]     typed_v,
    input logic [N-1:0]     level_v,
    input logic [N-1:0]     queued_v,
    input logic [N-1:0]     pend_v,
    input logic [N-1:0]     sent_v,
    input logic [7:0]       prio_a [N]
);
    a_r2_num_range: assert property (@(posedge clk) disable iff (!rst_n)
        ofr_valid |-> (ofr_num >= NUM_W'(BASE)) && (ofr_num < NUM_W'(BASE + N)));

    a_r9_offer_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        ofr_valid |-> ofr_prio != 8'hFF);

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r3_pending_masked: assert property (@(posedge clk) disable iff (!rst_n)
            pend_v[i] |-> prio_a[i] == 8'hFF);
        a_r4_level_offer_sent: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(queued_v[i]) && $past(level_v[i])) |-> sent_v[i]);
        a_r11_type_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            typed_v[i] |=> typed_v[i] && (level_v[i] == $past(level_v[i])));
    end
endmodule

bind irqsrc_ctrl irqsrc_ctrl_chk #(.N(N), .NUM_W(NUM_W), .BASE(BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .ofr_valid(ofr_valid), .ofr_num(ofr_num),
    .ofr_prio(ofr_prio), .typed_v(typed_v), .level_v(level_v),
    .queued_v(queued_v), .pend_v(pend_v), .sent_v(sent_v), .prio_a(prio_a));

// File: tb/irqsrc_ctrl_tb.sv
module irqsrc_ctrl_tb;
    localparam int N = 16;
    localparam int NUM_W = 16;
    localparam int BASE = 32'h1000;
    localparam int SRV_W = 8;
    localparam int IW = 4;

    logic clk = 0, rst_n = 0, soft_clr = 0;
    logic [N-1:0] src_in = '0;
    logic ty_we = 0, ty_level = 0, ty_err;
    logic [IW-1:0] ty_idx = '0, rt_idx = '0, rd_idx = '0;
    logic rt_we = 0;
    logic [SRV_W-1:0] rt_server = '0;
    logic [7:0] rt_prio = 8'hFF, rt_saved = 8'hFF;
    logic ofr_valid, ofr_ready = 0;
    logic [NUM_W-1:0] ofr_num;
    logic [7:0] ofr_prio;
    logic [SRV_W-1:0] ofr_server;
    logic rej_valid = 0, eoi_valid = 0, resend = 0;
    logic [NUM_W-1:0] rej_num = '0, eoi_num = '0;
    logic rd_typed, rd_level;
    logic [3:0] rd_flags;
    logic [7:0] rd_prio, rd_saved;
    logic [SRV_W-1:0] rd_server;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irqsrc_ctrl #(.N(N), .NUM_W(NUM_W), .BASE(BASE), .SRV_W(SRV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .src_in(src_in),
        .ty_we(ty_we), .ty_idx(ty_idx), .ty_level(ty_level), .ty_err(ty_err),
        .rt_we(rt_we), .rt_idx(rt_idx), .rt_server(rt_server), .rt_prio(rt_prio),
        .rt_saved(rt_saved), .ofr_valid(ofr_valid), .ofr_ready(ofr_ready),
        .ofr_num(ofr_num), .ofr_prio(ofr_prio), .ofr_server(ofr_server),
        .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid),
        .eoi_num(eoi_num), .resend(resend), .rd_idx(rd_idx), .rd_typed(rd_typed),
        .rd_level(rd_level), .rd_flags(rd_flags), .rd_prio(rd_prio),
        .rd_saved(rd_saved), .rd_server(rd_server));

    // ---------------- requirement model ----------------
    bit m_ty[N], m_lv[N], m_as[N], m_se[N], m_rj[N], m_pd[N], m_q[N];
    logic [7:0] m_pr[N], m_sv[N];
    logic [SRV_W-1:0] m_srv[N];
    bit m_err;

    function automatic int m_pick();
        int g = -1;
        for (int i = N - 1; i >= 0; i--) if (m_q[i]) g = i;
        return g;
    endfunction

    task automatic step_src(input int i, input int g);
        bit lv, sin, rw, mk, ev;
        lv = m_lv[i]; sin = src_in[i]; rw = rt_we && (rt_idx == IW'(i));
        if (soft_clr) begin
            m_as[i] = 0; m_se[i] = 0; m_rj[i] = 0; m_pd[i] = 0; m_q[i] = 0;
            m_srv[i] = '0; m_pr[i] = 8'hFF; m_sv[i] = 8'hFF;
            return;
        end
        if (ty_we && ty_idx == IW'(i) && !m_ty[i]) begin m_ty[i] = 1; m_lv[i] = ty_level; end
        if (g == i && ofr_ready) m_q[i] = 0;
        if (rej_valid && rej_num == NUM_W'(BASE + i)) begin
            if (lv) m_se[i] = 0; else m_rj[i] = 1;
        end
        if (eoi_valid && eoi_num == NUM_W'(BASE + i) && lv) m_se[i] = 0;
        if (rw) begin m_srv[i] = rt_server; m_pr[i] = rt_prio; m_sv[i] = rt_saved; end
        mk = (m_pr[i] == 8'hFF);
        if (rw && mk && m_q[i]) begin
            m_q[i] = 0;
            if (lv) m_se[i] = 0; else m_pd[i] = 1;
        end
        if (lv) begin
            ev = (sin != m_as[i]) || rw || resend;
            m_as[i] = sin; m_pd[i] = 0; m_rj[i] = 0;
            if (ev && !mk && sin && !m_se[i]) begin m_se[i] = 1; m_q[i] = 1; end
        end else begin
            if (resend && m_rj[i]) begin m_rj[i] = 0; if (!mk) m_q[i] = 1; end
            if (sin) begin if (mk) m_pd[i] = 1; else m_q[i] = 1; end
            if (rw && m_pd[i] && !mk) begin m_pd[i] = 0; m_q[i] = 1; end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_ty[i] = 0; m_lv[i] = 0; m_as[i] = 0; m_se[i] = 0; m_rj[i] = 0;
                m_pd[i] = 0; m_q[i] = 0; m_pr[i] = 8'hFF; m_sv[i] = 8'hFF; m_srv[i] = '0;
            end
            m_err = 0;
        end else begin
            int g;
            g = m_pick();
            m_err = ty_we && m_ty[ty_idx];
            for (int i = 0; i < N; i++) step_src(i, g);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the clock edge
    always begin
        @(negedge clk); #5;
        if (rst_n && !done) begin
            int g;
            g = m_pick();
            chk("R12 offer valid", ofr_valid, g >= 0);
            if (g >= 0) begin
                chk("R2 offer number", ofr_num, NUM_W'(BASE + g));
                chk("R3 offer priority", ofr_prio, m_pr[g]);
                chk("R3 offer server", ofr_server, m_srv[g]);
            end
            chk("R11 typed/level", {rd_typed, rd_level}, {m_ty[rd_idx], m_lv[rd_idx]});
            chk("R4 asserted flag", rd_flags[0], m_as[rd_idx]);
            chk("R5 sent flag", rd_flags[1], m_se[rd_idx]);
            chk("R6 rejected flag", rd_flags[2], m_rj[rd_idx]);
            chk("R3 pending flag", rd_flags[3], m_pd[rd_idx]);
            chk("R8 entry fields", {rd_prio, rd_saved, rd_server}, {m_pr[rd_idx], m_sv[rd_idx], m_srv[rd_idx]});
            chk("R11 error pulse", ty_err, m_err);
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic route(input int i, input logic [7:0] p, input logic [SRV_W-1:0] s);
        rt_we = 1; rt_idx = IW'(i); rt_prio = p; rt_saved = p ^ 8'h0F; rt_server = s;
        tick(); rt_we = 0;
    endtask

    task automatic strobe_rej(input int num);
        rej_valid = 1; rej_num = NUM_W'(num); tick(); rej_valid = 0;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        $display("FAIL watchdog expired");
        errors++;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F3A));
        repeat (3) tick();
        rst_n = 1; tick();
        rd_idx = 0; #1;
        chk("R1 reset prio", {rd_prio, rd_saved}, 16'hFFFF);
        chk("R1 reset flags", {rd_typed, rd_flags, rd_server}, 0);
        chk("R1 reset no offer", ofr_valid, 0);
        // types: 0..7 level, 8..15 message
        for (int i = 0; i < N; i++) begin
            ty_we = 1; ty_idx = IW'(i); ty_level = (i < 8); tick();
        end
        ty_we = 1; ty_idx = 2; ty_level = 0; tick(); ty_we = 0;
        rd_idx = 2; #1;
        chk("R11 second assign error", ty_err, 1);
        chk("R11 type kept", rd_level, 1);
        // R3 masked message arrival
        src_in[9] = 1; tick(); src_in[9] = 0; rd_idx = 9; #1;
        chk("R3 masked pending", rd_flags, 4'b1000);
        chk("R3 masked no offer", ofr_valid, 0);
        route(9, 8'h05, 8'h03); #1;
        chk("R8 unmask offers", {ofr_valid, ofr_num, ofr_prio, ofr_server}, {1'b1, 16'h1009, 8'h05, 8'h03});
        chk("R8 pending cleared", rd_flags, 4'b0000);
        ofr_ready = 1; tick(); ofr_ready = 0;
        chk("R12 accepted leaves", ofr_valid, 0);
        // R4 level
        route(0, 8'h03, 8'h01);
        src_in[0] = 1; tick(); rd_idx = 0; #1;
        chk("R4 level offer", {ofr_valid, ofr_num}, {1'b1, 16'h1000});
        chk("R4 sent+asserted", rd_flags, 4'b0011);
        ofr_ready = 1; tick(); ofr_ready = 0; tick();
        chk("R4 no re-offer while high", ofr_valid, 0);
        eoi_valid = 1; eoi_num = 16'h1000; tick(); eoi_valid = 0;
        chk("R7 eoi clears sent", rd_flags, 4'b0001);
        chk("R7 eoi does not offer", ofr_valid, 0);
        eoi_valid = 1; eoi_num = 16'h1009; tick(); eoi_valid = 0; rd_idx = 9; #1;
        chk("R7 eoi message no effect", rd_flags, 4'b0000);
        resend = 1; tick(); resend = 0; rd_idx = 0; #1;
        chk("R6 level resend offer", {ofr_valid, ofr_num}, {1'b1, 16'h1000});
        ofr_ready = 1; tick(); ofr_ready = 0;
        strobe_rej(32'h1000); #1;
        chk("R5 level reject clears sent", rd_flags, 4'b0001);
        strobe_rej(32'h1009); rd_idx = 9; #1;
        chk("R5 message reject sets flag", rd_flags, 4'b0100);
        resend = 1; tick(); resend = 0; #1;
        chk("R6 rejected cleared", rd_flags, 4'b0000);
        chk("R6 lowest first", ofr_num, 16'h1000);
        ofr_ready = 1; tick(); #1;
        chk("R6 message reoffered", ofr_num, 16'h1009);
        tick(); ofr_ready = 0;
        // R13 reject and resend in one cycle on a sent level source
        rej_valid = 1; rej_num = 16'h1000; resend = 1; tick(); rej_valid = 0; resend = 0;
        rd_idx = 0; #1;
        chk("R13 reject then offer", {ofr_valid, ofr_num, rd_flags[1]}, {1'b1, 16'h1000, 1'b1});
        ofr_ready = 1; tick(); ofr_ready = 0;
        // R9 mask a queued message
        route(11, 8'h07, 8'h02);
        src_in[11] = 1; tick(); src_in[11] = 0; #1;
        chk("R9 queued", ofr_num, 16'h100B);
        route(11, 8'hFF, 8'h02); rd_idx = 11; #1;
        chk("R9 withdrawn", ofr_valid, 0);
        chk("R9 now pending", rd_flags, 4'b1000);
        // R2 out of range strobes
        strobe_rej(32'h0FFF); strobe_rej(32'h1010); rd_idx = 0; #1;
        chk("R2 out of range ignored", rd_flags, 4'b0011);
        // R12 ordering with stall
        route(12, 8'h04, 8'h00); route(10, 8'h04, 8'h00);
        src_in[12] = 1; src_in[10] = 1; tick(); src_in = '0; src_in[0] = 1; #1;
        chk("R12 lowest index", ofr_num, 16'h100A);
        tick();
        chk("R12 held while stalled", ofr_num, 16'h100A);
        ofr_ready = 1; tick(); #1;
        chk("R12 next after accept", ofr_num, 16'h100C);
        tick(); ofr_ready = 0;
        // R10 soft clear keeps type
        soft_clr = 1; tick(); soft_clr = 0; rd_idx = 3; #1;
        chk("R10 type kept", {rd_typed, rd_level, rd_prio}, {1'b1, 1'b1, 8'hFF});
        chk("R10 no offer", ofr_valid, 0);
        src_in = '0;
        // random phase
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk); #1;
            for (int i = 0; i < N; i++)
                src_in[i] = (i < 8) ? (($urandom % 8 == 0) ? ~src_in[i] : src_in[i])
                                    : ($urandom % 10 == 0);
            rt_we = ($urandom % 6 == 0); rt_idx = IW'($urandom);
            rt_prio = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom % 16);
            rt_saved = 8'($urandom); rt_server = SRV_W'($urandom);
            rej_valid = ($urandom % 5 == 0); rej_num = NUM_W'(32'h0FFE + $urandom % 20);
            eoi_valid = ($urandom % 5 == 0); eoi_num = NUM_W'(32'h0FFE + $urandom % 20);
            resend = ($urandom % 12 == 0);
            ofr_ready = ($urandom % 3 != 0);
            ty_we = ($urandom % 50 == 0); ty_idx = IW'($urandom); ty_level = 1'($urandom);
            soft_clr = ($urandom % 400 == 0);
            rd_idx = IW'($urandom);
        end
        @(negedge clk); #1;
        rt_we = 0; rej_valid = 0; eoi_valid = 0; resend = 0; ty_we = 0; soft_clr = 0;
        repeat (2) @(negedge clk);
        #7 done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule